// File: doc/BRIEF.md
# Store Buffer With Ordering Control

This block sits between a processor's load/store port and a memory port with variable latency. Stores are written into a small first-in first-out buffer and retire to memory one at a time, oldest first. The processor is then free to keep issuing work while the writes drain.

An ordering input selects one of two policies. Under relaxed ordering, a load that misses the buffer goes to memory ahead of any stores still waiting. A load whose address matches a waiting store is answered at once from the youngest such store. Under sequential consistency, each new access waits until every earlier access has finished, so memory sees all accesses in program order. In both modes a fence request holds the processor until the buffer is empty. A single stall output tells the processor to keep its current request on the port.

Top module: `sbuf_order_top`

## Requirements
- R1: After a synchronous active-low reset, with no request presented, `cpu_stall`, `ld_done` and `mem_req` are all 0 and the buffer is empty.
- R2: Requests use `cpu_valid` with `cpu_op` 0 = store, 1 = load, 2 = fence. In relaxed mode (`mode_sc` = 0), a store is accepted (`cpu_stall` = 0) in the cycle it is presented whenever fewer than DEPTH stores are buffered.
- R3: In relaxed mode, a store presented while DEPTH stores are buffered stalls. The stall drops in the cycle after the memory acknowledge that retires the oldest entry.
- R4: Buffered stores reach memory one at a time in acceptance order. `mem_req` with `mem_we` = 1 stays high, with address and data stable, until `mem_ack`. Once the buffer has drained, memory holds the last stored value of every address.
- R5: In relaxed mode, a load whose address matches one or more buffered stores completes in the cycle it is presented. It returns the data of the youngest matching store and starts no memory access.
- R6: In relaxed mode, a load that misses the buffer stalls. When the memory port is idle, the read is issued ahead of any waiting store, although a write already in flight completes first. `ld_done` and the data appear in the cycle after the read acknowledge.
- R7: In sequential-consistency mode (`mode_sc` = 1), a store or a load stalls while any store is buffered. No access is accepted while a memory transaction is outstanding, so every access finishes before the next one starts.
- R8: A fence stalls in either mode until the buffer is empty and is accepted in the first cycle it is empty. The cycle after a fence is accepted, `mem_req` is 0.
- R9: Every completed load returns the value of the latest earlier accepted store to the same address, or the memory's initial content if there is none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sc | input | 1 | 1 = sequential consistency, 0 = relaxed; change only while the buffer is empty |
| cpu_valid | input | 1 | Processor request present |
| cpu_op | input | 2 | 0 store, 1 load, 2 fence |
| cpu_addr | input | AW | Access address |
| cpu_wdata | input | DW | Store data |
| cpu_stall | output | 1 | Request not taken this cycle; hold it |
| ld_done | output | 1 | Load completes this cycle |
| ld_data | output | DW | Load result, valid with ld_done |
| mem_req | output | 1 | Memory transaction pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Memory address |
| mem_wdata | output | DW | Memory write data |
| mem_ack | input | 1 | Memory completes the pending transaction this cycle |
| mem_rdata | input | DW | Read data, valid with mem_ack |

## Verification
The bench targets these corner cases:

- **Two stores to one address, then a load of it.** Forwarding that picks the oldest match instead of the youngest returns stale data.
- **A load that misses while stores wait.** A design that lets the drain start first, or that returns data a cycle early or late, breaks the cycle-exact comparison.
- **A store arriving while the buffer is full.** An off-by-one full flag either overwrites an entry or stalls needlessly.
- **Sequential-consistency loads and stores issued over a pending write, and fences after mixed traffic.** Any early release shows up as an accepted access while memory is busy, or as a final memory image that differs from program order.

// File: rtl/sbuf_pkg.sv
// Shared encodings for the store buffer block.
// Assumes: the processor encodes one request per cycle on a 2-bit opcode.
package sbuf_pkg;

    typedef enum logic [1:0] {
        OP_STORE = 2'd0,
        OP_LOAD  = 2'd1,
        OP_FENCE = 2'd2
    } cpu_op_e;

    typedef enum logic [1:0] {
        MP_IDLE  = 2'd0,
        MP_WRITE = 2'd1,
        MP_READ  = 2'd2
    } mport_e;

endpackage

// File: rtl/sbuf_fifo.sv
// Circular buffer of pending stores with an associative lookup port.
// Push writes the tail, pop retires the head. The lookup reports the
// youngest valid entry whose address equals lookup_addr.
// Assumes: the controller never pushes when full nor pops when empty.
module sbuf_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [AW-1:0] lookup_addr,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          full,
    output logic          empty
);

    logic [AW-1:0] addr_mem [DEPTH];
    logic [DW-1:0] data_mem [DEPTH];
    logic [PW-1:0] head_q;
    logic [PW-1:0] tail_q;
    logic [CW-1:0] count_q;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + PW'(1);
    endfunction

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q  <= '0;
            tail_q  <= '0;
            count_q <= '0;
        end else begin
            if (push) tail_q <= ptr_inc(tail_q);
            if (pop)  head_q <= ptr_inc(head_q);
            if (push && !pop)      count_q <= count_q + CW'(1);
            else if (!push && pop) count_q <= count_q - CW'(1);
        end
    end

    // Entry storage; contents need no reset since count gates them.
    always_ff @(posedge clk) begin
        if (push) begin
            addr_mem[tail_q] <= push_addr;
            data_mem[tail_q] <= push_data;
        end
    end

    // Scan oldest to youngest so the last match found is the youngest.
    always_comb begin
        logic [PW:0]   sum;
        logic [PW-1:0] idx;
        hit      = 1'b0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            sum = {1'b0, head_q} + (PW+1)'(i);
            if (sum >= (PW+1)'(DEPTH)) sum = sum - (PW+1)'(DEPTH);
            idx = sum[PW-1:0];
            if ((CW'(i) < count_q) && (addr_mem[idx] == lookup_addr)) begin
                hit      = 1'b1;
                hit_data = data_mem[idx];
            end
        end
    end

    assign head_addr = addr_mem[head_q];
    assign head_data = data_mem[head_q];
    assign full      = (count_q == CW'(DEPTH));
    assign empty     = (count_q == '0);

    // R3: the controller must never write into a full buffer.
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);

    // R4: retirement only happens with an entry present.
    assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);

endmodule

// File: rtl/sbuf_mem_seq.sv
// Memory port sequencer: owns the single outstanding memory transaction.
// From idle, a read request from the controller wins over draining the
// buffer head. A transaction holds until mem_ack. Read data is captured
// and flagged ready until the controller consumes it.
// Assumes: rd_issue is raised only while idle is high.
module sbuf_mem_seq
    import sbuf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_issue,
    input  logic [AW-1:0] rd_addr,
    input  logic          drain_avail,
    input  logic [AW-1:0] head_addr,
    input  logic [DW-1:0] head_data,
    input  logic          rd_consume,
    output logic          idle,
    output logic          pop,
    output logic          rd_ready,
    output logic [DW-1:0] rd_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    mport_e        state_q;
    mport_e        state_nx;
    logic [AW-1:0] rd_addr_q;
    logic [DW-1:0] rd_data_q;
    logic          rd_ready_q;

    // Next transaction choice: read first, then drain, else stay idle.
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            MP_IDLE: begin
                if (rd_issue)         state_nx = MP_READ;
                else if (drain_avail) state_nx = MP_WRITE;
            end
            MP_WRITE, MP_READ: begin
                if (mem_ack) state_nx = MP_IDLE;
            end
            default: state_nx = MP_IDLE;
        endcase
    end

    // Transaction state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MP_IDLE;
        else        state_q <= state_nx;
    end

    // Latch the read address when a read starts.
    always_ff @(posedge clk) begin
        if (!rst_n)                             rd_addr_q <= '0;
        else if (state_q == MP_IDLE && rd_issue) rd_addr_q <= rd_addr;
    end

    // Capture read data on acknowledge; hold it until consumed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ready_q <= 1'b0;
            rd_data_q  <= '0;
        end else if (state_q == MP_READ && mem_ack) begin
            rd_ready_q <= 1'b1;
            rd_data_q  <= mem_rdata;
        end else if (rd_consume) begin
            rd_ready_q <= 1'b0;
        end
    end

    assign idle      = (state_q == MP_IDLE);
    assign pop       = (state_q == MP_WRITE) && mem_ack;
    assign rd_ready  = rd_ready_q;
    assign rd_data   = rd_data_q;
    assign mem_req   = (state_q != MP_IDLE);
    assign mem_we    = (state_q == MP_WRITE);
    assign mem_addr  = (state_q == MP_WRITE) ? head_addr : rd_addr_q;
    assign mem_wdata = head_data;

    // R4: a pending transaction keeps its attributes until acknowledged.
    assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) &&
                                   $stable(mem_addr) && $stable(mem_wdata)));

    // R6: read data is flagged ready in the cycle after its acknowledge.
    assert_read_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> rd_ready);

endmodule

// File: rtl/sbuf_order_ctl.sv
// Request controller: decides, per cycle, whether the processor request
// is taken. It applies the ordering mode, forwarding, the full check and
// the fence drain wait, and it drives buffer push and read issue.
// Assumes: the processor holds its request unchanged while cpu_stall is
// high, and mode_sc changes only while the buffer is empty.
module sbuf_order_ctl
    import sbuf_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sc,
    input  logic          cpu_valid,
    input  logic [1:0]    cpu_op,
    input  logic          buf_empty,
    input  logic          buf_full,
    input  logic          buf_hit,
    input  logic [DW-1:0] buf_hit_data,
    input  logic          port_idle,
    input  logic          rd_ready,
    input  logic [DW-1:0] rd_data,
    output logic          cpu_stall,
    output logic          ld_done,
    output logic [DW-1:0] ld_data,
    output logic          push,
    output logic          rd_issue,
    output logic          rd_consume
);

    logic is_store;
    logic is_load;
    logic is_fence;
    logic fwd_ok;
    logic ld_wait_q;

    assign is_store = cpu_valid && (cpu_op == OP_STORE);
    assign is_load  = cpu_valid && (cpu_op == OP_LOAD);
    assign is_fence = cpu_valid && (cpu_op == OP_FENCE);
    assign fwd_ok   = !mode_sc && buf_hit;

    // Per-request acceptance, forwarding and read issue decisions.
    always_comb begin
        cpu_stall  = 1'b0;
        ld_done    = 1'b0;
        ld_data    = '0;
        push       = 1'b0;
        rd_issue   = 1'b0;
        rd_consume = 1'b0;
        if (is_store) begin
            cpu_stall = mode_sc ? !buf_empty : buf_full;
            push      = !cpu_stall;
        end else if (is_load) begin
            if (fwd_ok) begin
                ld_done = 1'b1;
                ld_data = buf_hit_data;
            end else if (rd_ready) begin
                ld_done    = 1'b1;
                ld_data    = rd_data;
                rd_consume = 1'b1;
            end else begin
                cpu_stall = 1'b1;
                rd_issue  = !ld_wait_q && port_idle && (!mode_sc || buf_empty);
            end
        end else if (is_fence) begin
            cpu_stall = !buf_empty;
        end
    end

    // Track an issued read until its data is handed to the processor.
    always_ff @(posedge clk) begin
        if (!rst_n)          ld_wait_q <= 1'b0;
        else if (rd_issue)   ld_wait_q <= 1'b1;
        else if (rd_consume) ld_wait_q <= 1'b0;
    end

    // R6: data can be handed over only for a read this controller issued.
    assert_consume_issued_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_consume |-> ld_wait_q);

    // R5: a forwarded load never starts a memory read.
    assert_fwd_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (is_load && fwd_ok) |-> !rd_issue);

endmodule

// File: rtl/sbuf_order_top.sv
// Store buffer with selectable memory ordering and fence support.
// It connects the request controller, the store FIFO and the memory port
// sequencer.
// Assumes: memory accepts one transaction at a time and answers with
// mem_ack after any number of cycles, including zero.
module sbuf_order_top
    import sbuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 8,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_sc,
    input  logic          cpu_valid,
    input  logic [1:0]    cpu_op,
    input  logic [AW-1:0] cpu_addr,
    input  logic [DW-1:0] cpu_wdata,
    output logic          cpu_stall,
    output logic          ld_done,
    output logic [DW-1:0] ld_data,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_ack,
    input  logic [DW-1:0] mem_rdata
);

    logic          push;
    logic          pop;
    logic          buf_hit;
    logic [DW-1:0] buf_hit_data;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic          buf_full;
    logic          buf_empty;
    logic          port_idle;
    logic          rd_ready;
    logic [DW-1:0] rd_data;
    logic          rd_issue;
    logic          rd_consume;

    sbuf_order_ctl #(.AW(AW), .DW(DW)) u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_sc      (mode_sc),
        .cpu_valid    (cpu_valid),
        .cpu_op       (cpu_op),
        .buf_empty    (buf_empty),
        .buf_full     (buf_full),
        .buf_hit      (buf_hit),
        .buf_hit_data (buf_hit_data),
        .port_idle    (port_idle),
        .rd_ready     (rd_ready),
        .rd_data      (rd_data),
        .cpu_stall    (cpu_stall),
        .ld_done      (ld_done),
        .ld_data      (ld_data),
        .push         (push),
        .rd_issue     (rd_issue),
        .rd_consume   (rd_consume)
    );

    sbuf_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (push),
        .push_addr   (cpu_addr),
        .push_data   (cpu_wdata),
        .pop         (pop),
        .lookup_addr (cpu_addr),
        .hit         (buf_hit),
        .hit_data    (buf_hit_data),
        .head_addr   (head_addr),
        .head_data   (head_data),
        .full        (buf_full),
        .empty       (buf_empty)
    );

    sbuf_mem_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .rd_issue    (rd_issue),
        .rd_addr     (cpu_addr),
        .drain_avail (!buf_empty),
        .head_addr   (head_addr),
        .head_data   (head_data),
        .rd_consume  (rd_consume),
        .idle        (port_idle),
        .pop         (pop),
        .rd_ready    (rd_ready),
        .rd_data     (rd_data),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata)
    );

    // R7: under sequential consistency no access is taken while memory is busy.
    assert_sc_serial_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sc && cpu_valid && (cpu_op != OP_FENCE) && !cpu_stall) |-> !mem_req);

    // R8: once a fence is taken, nothing is left to send to memory.
    assert_fence_drained_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && (cpu_op == OP_FENCE) && !cpu_stall) |=> !mem_req);

    // R1: no transaction is pending right after reset.
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !mem_req);

endmodule

// File: tb/sbuf_order_top_tb.sv
// Cycle-by-cycle bench: a behavioural model (queues, integers) predicts
// stall, load completion and the memory port every cycle. A shadow array
// holds the program-order value of each address.
module sbuf_order_top_tb;

    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int DW    = 16;
    localparam int NADDR = 16;
    localparam int LIMIT = 100000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_sc = 1'b0;
    logic          cpu_valid = 1'b0;
    logic [1:0]    cpu_op = 2'd0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_stall;
    logic          ld_done;
    logic [DW-1:0] ld_data;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_ack = 1'b0;
    logic [DW-1:0] mem_rdata = '0;

    always #4 clk = ~clk;

    sbuf_order_top #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sc(mode_sc), .cpu_valid(cpu_valid),
        .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_stall(cpu_stall), .ld_done(ld_done), .ld_data(ld_data),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;
    typedef struct packed { logic [2:0] k; logic [AW-1:0] a; logic [DW-1:0] d; } op_t;

    ent_t          mq[$];
    op_t           prog[$];
    op_t           cur;
    logic [DW-1:0] mem  [NADDR];
    logic [DW-1:0] arch [NADDR];
    int            n_vec = 0;
    int            n_err = 0;
    int            cyc = 0;
    int            mport = 0;
    int            nport;
    int            mcnt = 0;
    bit            mbusy = 0;
    bit            mrdy = 0;
    bit            mwait = 0;
    bit            have = 0;
    bit            gen_sc = 0;
    logic [AW-1:0] mraddr = '0;
    logic [DW-1:0] mrdata = '0;
    bit            e_stall, e_done, e_issue, hit, accept;
    logic [DW-1:0] e_data, hd;
    string         tag;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", rq, what, act, exp, cyc);
        end
    endtask

    task automatic add(input int k, input int a, input int d);
        op_t o;
        o.k = 3'(k); o.a = AW'(a); o.d = DW'(d);
        prog.push_back(o);
    endtask

    initial begin
        for (int i = 0; i < NADDR; i++) begin
            mem[i]  = DW'(16'h1000 + i * 17);
            arch[i] = mem[i];
        end
        // Directed: fill past DEPTH (R2, R3), youngest forward (R5).
        add(4, 0, 0);
        for (int i = 1; i <= 6; i++) add(1, i, 16'h0100 + i);
        add(1, 2, 16'hAAAA); add(1, 2, 16'hBBBB); add(2, 2, 0);
        // Miss while stores wait (R6), then fence (R8) and reload (R4, R9).
        add(2, 9, 0); add(3, 0, 0); add(2, 2, 0);
        // Sequential consistency (R7).
        add(5, 0, 0);
        add(1, 4, 16'h4444); add(2, 4, 0); add(1, 5, 16'h5555);
        add(2, 11, 0); add(1, 6, 16'h6666); add(1, 7, 16'h7777);
        add(3, 0, 0); add(4, 0, 0);
        // Random mix.
        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 45)      add(1, $urandom_range(0, 7), $urandom_range(0, 65535));
            else if (r < 85) add(2, $urandom_range(0, 9), 0);
            else if (r < 91) add(3, 0, 0);
            else if (r < 96) add(0, 0, 0);
            else begin
                add(3, 0, 0);
                gen_sc = !gen_sc;
                add(gen_sc ? 5 : 4, 0, 0);
            end
        end
        add(3, 0, 0);

        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        chk(cpu_stall === 1'b0, "R1", "stall in reset", 32'(cpu_stall), 0);
        chk(ld_done === 1'b0, "R1", "ld_done in reset", 32'(ld_done), 0);
        chk(mem_req === 1'b0, "R1", "mem_req in reset", 32'(mem_req), 0);
        rst_n = 1'b1;

        while (cyc < LIMIT && (prog.size() > 0 || have || mq.size() > 0 || mport != 0)) begin
            @(negedge clk);
            cyc++;
            // Memory responder with 0..3 wait cycles.
            if (mem_ack) mbusy = 0;
            else if (mbusy) mcnt--;
            mem_ack = 1'b0;
            if (mem_req) begin
                if (!mbusy) begin mbusy = 1; mcnt = $urandom_range(0, 3); end
                if (mcnt == 0) begin
                    mem_ack = 1'b1;
                    if (mem_we) mem[mem_addr[3:0]] = mem_wdata;
                    else        mem_rdata = mem[mem_addr[3:0]];
                end
            end
            // Processor side.
            if (!have && prog.size() > 0) begin cur = prog.pop_front(); have = 1; end
            cpu_valid = 1'b0;
            if (have) begin
                if (cur.k == 0) have = 0;
                else if (cur.k >= 4) begin mode_sc = (cur.k == 5); have = 0; end
                else begin
                    cpu_valid = 1'b1;
                    cpu_op    = 2'(cur.k - 1);
                    cpu_addr  = cur.a;
                    cpu_wdata = cur.d;
                end
            end
            // Expected outputs from the model state.
            e_stall = 0; e_done = 0; e_data = '0; e_issue = 0; hit = 0; hd = '0; tag = "R1";
            if (cpu_valid) begin
                case (cur.k)
                    3'd1: begin
                        if (mode_sc) begin e_stall = (mq.size() != 0); tag = "R7"; end
                        else begin e_stall = (mq.size() >= DEPTH); tag = e_stall ? "R3" : "R2"; end
                    end
                    3'd2: begin
                        if (!mode_sc)
                            foreach (mq[i]) if (mq[i].a == cur.a) begin hit = 1; hd = mq[i].d; end
                        if (hit) begin e_done = 1; e_data = hd; tag = "R5"; end
                        else if (mrdy) begin e_done = 1; e_data = mrdata; tag = mode_sc ? "R7" : "R6"; end
                        else begin
                            e_stall = 1; tag = mode_sc ? "R7" : "R6";
                            e_issue = !mwait && mport == 0 && (!mode_sc || mq.size() == 0);
                        end
                    end
                    default: begin e_stall = (mq.size() != 0); tag = "R8"; end
                endcase
            end
            #1;
            chk(cpu_stall === e_stall, tag, "cpu_stall", 32'(cpu_stall), 32'(e_stall));
            chk(ld_done === e_done, tag, "ld_done", 32'(ld_done), 32'(e_done));
            if (e_done) begin
                chk(ld_data === e_data, tag, "ld_data", 32'(ld_data), 32'(e_data));
                chk(ld_data === arch[cur.a[3:0]], "R9", "program-order value",
                    32'(ld_data), 32'(arch[cur.a[3:0]]));
            end
            chk(mem_req === (mport != 0), (mport == 2) ? "R6" : "R4", "mem_req",
                32'(mem_req), 32'(mport != 0));
            if (mport == 1)
                chk(mem_we === 1'b1 && mem_addr === mq[0].a && mem_wdata === mq[0].d, "R4",
                    "write beat", {7'd0, mem_we, mem_addr, mem_wdata}, {8'd1, mq[0].a, mq[0].d});
            if (mport == 2)
                chk(mem_we === 1'b0 && mem_addr === mraddr, "R6", "read beat",
                    {23'd0, mem_we, mem_addr}, {24'd0, mraddr});
            // Advance the model across the coming edge.
            accept = cpu_valid && !e_stall;
            nport  = mport;
            if (mport == 1 && mem_ack) begin mq.delete(0); nport = 0; end
            else if (mport == 2 && mem_ack) begin mrdy = 1; mrdata = mem_rdata; nport = 0; end
            else if (mport == 0) begin
                if (e_issue) begin nport = 2; mraddr = cur.a; mwait = 1; end
                else if (mq.size() > 0) nport = 1;
            end
            if (accept) begin
                have = 0;
                if (cur.k == 1) begin
                    ent_t e;
                    e.a = cur.a; e.d = cur.d;
                    mq.push_back(e);
                    arch[cur.a[3:0]] = cur.d;
                end
                if (cur.k == 2 && !hit) begin mrdy = 0; mwait = 0; end
            end
            mport = nport;
        end

        if (cyc >= LIMIT) chk(1'b0, "R4", "watchdog expired", 32'(cyc), LIMIT);
        @(negedge clk);
        cpu_valid = 1'b0;
        // R4: drained memory image equals program order.
        for (int i = 0; i < NADDR; i++)
            chk(mem[i] === arch[i], "R4", "final memory", 32'(mem[i]), 32'(arch[i]));
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
        $finish;
    end

endmodule